// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block is the control unit of a multicycle processor that executes a small load/store instruction subset: register-to-register ALU operations, OR with an immediate, branch-if-equal, word load and word store. A 4-bit micro-state register indexes a microcode table. Each table word holds the datapath strobes for that state and a two-bit sequencing field. The sequencing field picks the next state in one of three ways: return to the fetch state, jump through an opcode-indexed dispatch table, or step to the next state in order.

The datapath, the register file and a single shared instruction/data memory sit outside this block. They receive the strobes and return the instruction's opcode and function field, plus a registered equality flag from the ALU comparison. Every strobe is a decode of the micro-state register. The opcode reaches the next state only through the dispatch table. The function field reaches only the ALU function output, and only in the register-operation execute state. The equality flag reaches only the PC write strobe, and only in the branch completion state. An opcode that has no dispatch entry sends the sequencer back to fetch and raises a one-cycle illegal-instruction flag.

Top module: `ucodeSequencer`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets `uState` to 0 and clears `illegalOp` at that edge. This holds whatever state or pending dispatch the sequencer was in.
- R2: State 0 (fetch) drives pcWrite=1, pcSrc=0, irLoad=1, memRead=1, memAddrSel=0 (PC), aluSelA=0 (PC), aluSelB=01 (constant 4), aluFunc=0010 (add). It always moves to state 1.
- R3: State 1 (decode) asserts no strobe. Its next state comes from the opcode: 000000 goes to 4, 000100 to 2, 001101 to 6, 100011 to 8 and 101011 to 11.
- R4: Branch. State 2 drives aluSelA=1, aluSelB=00, aluFunc=0110 (subtract) and moves to 3. State 3 drives aluSelA=0, aluSelB=11 (shifted extended immediate), extSign=1 and pcSrc=1. In state 3, pcWrite equals `aluEqual`, and the next state is 0.
- R5: Register operation. State 4 drives aluSelA=1 and aluSelB=00, takes aluFunc from the function field, and moves to 5. State 5 drives regWrite=1, regDst=1 (rd) and regSrc=0 (ALU), then moves to 0.
- R6: OR-immediate. State 6 drives aluSelA=1, aluSelB=10 (extended immediate), extSign=0 and aluFunc=0001 (or), then moves to 7. State 7 drives regWrite=1, regDst=0 (rt) and regSrc=0, then moves to 0.
- R7: Load. State 8 drives aluSelA=1, aluSelB=10, extSign=1 and aluFunc=0010. State 9 drives memRead=1 and memAddrSel=1 (ALU result). State 10 drives regWrite=1, regDst=0 and regSrc=1 (memory). The states run 8, 9, 10 and then 0.
- R8: Store. State 11 drives the same strobes as state 8. State 12 drives memWrite=1 and memAddrSel=1, then moves to 0.
- R9: An opcode outside the R3 list sends state 1 to state 0. `illegalOp` is then 1 for exactly that next cycle and 0 otherwise.
- R10: In state 4, the function field maps to aluFunc as follows: 100000 to 0010, 100010 to 0110, 100100 to 0000, 100101 to 0001, 101010 to 0111, and any other value to 1111.
- R11: Each output that R2 to R8 does not name for a state is 0 in that state, except aluFunc, which is 0010. Neither the opcode nor the function field changes any output in a state where R2 to R8 do not use them. `aluEqual` affects pcWrite only in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction held in the datapath IR |
| funct | input | 6 | Function field of the held instruction |
| aluEqual | input | 1 | Registered equality flag from the datapath comparison |
| uState | output | 4 | Current micro-state |
| pcWrite | output | 1 | Load the PC this cycle |
| pcSrc | output | 1 | PC source: 0 incremented PC, 1 branch target |
| irLoad | output | 1 | Load the instruction register from memory |
| aluSelA | output | 1 | ALU operand A: 0 PC, 1 register A |
| aluSelB | output | 2 | ALU operand B: 00 reg B, 01 four, 10 ext imm, 11 ext imm shifted |
| aluFunc | output | 4 | ALU function code |
| extSign | output | 1 | Immediate extension: 1 sign, 0 zero |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memAddrSel | output | 1 | Memory address: 0 PC, 1 ALU result |
| regWrite | output | 1 | Register file write strobe |
| regDst | output | 1 | Destination register: 0 rt, 1 rd |
| regSrc | output | 1 | Write data: 0 ALU result, 1 memory |
| illegalOp | output | 1 | One-cycle flag after dispatch on an unknown opcode |

## Verification
The strobes are decodes of the state register, so they are valid in the same cycle as `uState`. A rising edge moves `uState` to its successor, and the illegal flag and reset both take effect at the first rising edge after their cause. The bench changes inputs and samples outputs 5 ns after each rising edge. It checks the state and the full 17-bit strobe word each cycle against a model of the requirements. It checks `illegalOp` one edge after each decode, and `uState` one edge after reset is applied. It sweeps all 64 opcodes with both equality values and all 64 function codes, which also covers the unknown-opcode and unknown-function cases.

// File: rtl/ucodePkg.sv
package ucodePkg;

  localparam int STATE_W = 4;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int AFN_W   = 4;

  typedef enum logic [1:0] {
    SEQ_ZERO = 2'd0,
    SEQ_DISP = 2'd1,
    SEQ_INC  = 2'd2
  } seqSel_e;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_OR    = 2'd2,
    OP_FUNCT = 2'd3
  } aluOp_e;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMMS = 2'b11;

  localparam logic [STATE_W-1:0] ST_FETCH   = 4'd0;
  localparam logic [STATE_W-1:0] ST_DECODE  = 4'd1;
  localparam logic [STATE_W-1:0] ST_BR_CMP  = 4'd2;
  localparam logic [STATE_W-1:0] ST_BR_TAKE = 4'd3;
  localparam logic [STATE_W-1:0] ST_RR_EXEC = 4'd4;
  localparam logic [STATE_W-1:0] ST_RR_WB   = 4'd5;
  localparam logic [STATE_W-1:0] ST_OI_EXEC = 4'd6;
  localparam logic [STATE_W-1:0] ST_OI_WB   = 4'd7;
  localparam logic [STATE_W-1:0] ST_LD_ADDR = 4'd8;
  localparam logic [STATE_W-1:0] ST_LD_MEM  = 4'd9;
  localparam logic [STATE_W-1:0] ST_LD_WB   = 4'd10;
  localparam logic [STATE_W-1:0] ST_ST_ADDR = 4'd11;
  localparam logic [STATE_W-1:0] ST_ST_MEM  = 4'd12;
  localparam logic [STATE_W-1:0] ST_LAST    = ST_ST_MEM;

  localparam logic [OPC_W-1:0] OPC_RREG = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;

  localparam logic [AFN_W-1:0] AFN_AND = 4'b0000;
  localparam logic [AFN_W-1:0] AFN_OR  = 4'b0001;
  localparam logic [AFN_W-1:0] AFN_ADD = 4'b0010;
  localparam logic [AFN_W-1:0] AFN_SUB = 4'b0110;
  localparam logic [AFN_W-1:0] AFN_SLT = 4'b0111;
  localparam logic [AFN_W-1:0] AFN_BAD = 4'b1111;

  // Strobe word handed from the microcode table to the outputs.
  typedef struct packed {
    logic       pcWr;
    logic       pcWrCond;
    logic       pcSrc;
    logic       irLoad;
    logic       aluSelA;
    logic [1:0] aluSelB;
    aluOp_e     aluOp;
    logic       extSign;
    logic       memRd;
    logic       memWr;
    logic       memAddrSel;
    logic       regWr;
    logic       regDst;
    logic       regSrc;
    seqSel_e    seq;
  } ctrlWord_t;

  function automatic ctrlWord_t ucodeEntry(input logic [STATE_W-1:0] s);
    ctrlWord_t w;
    w = '0;
    w.aluOp = OP_ADD;
    w.seq   = SEQ_ZERO;
    case (s)
      ST_FETCH: begin
        w.pcWr = 1'b1; w.irLoad = 1'b1; w.memRd = 1'b1;
        w.aluSelB = SRCB_FOUR; w.seq = SEQ_INC;
      end
      ST_DECODE:  w.seq = SEQ_DISP;
      ST_BR_CMP: begin
        w.aluSelA = 1'b1; w.aluSelB = SRCB_REG; w.aluOp = OP_SUB;
        w.seq = SEQ_INC;
      end
      ST_BR_TAKE: begin
        w.pcWrCond = 1'b1; w.pcSrc = 1'b1;
        w.aluSelB = SRCB_IMMS; w.extSign = 1'b1;
      end
      ST_RR_EXEC: begin
        w.aluSelA = 1'b1; w.aluSelB = SRCB_REG; w.aluOp = OP_FUNCT;
        w.seq = SEQ_INC;
      end
      ST_RR_WB: begin
        w.regWr = 1'b1; w.regDst = 1'b1;
      end
      ST_OI_EXEC: begin
        w.aluSelA = 1'b1; w.aluSelB = SRCB_IMM; w.aluOp = OP_OR;
        w.seq = SEQ_INC;
      end
      ST_OI_WB:   w.regWr = 1'b1;
      ST_LD_ADDR, ST_ST_ADDR: begin
        w.aluSelA = 1'b1; w.aluSelB = SRCB_IMM; w.extSign = 1'b1;
        w.seq = SEQ_INC;
      end
      ST_LD_MEM: begin
        w.memRd = 1'b1; w.memAddrSel = 1'b1; w.seq = SEQ_INC;
      end
      ST_LD_WB: begin
        w.regWr = 1'b1; w.regSrc = 1'b1;
      end
      ST_ST_MEM: begin
        w.memWr = 1'b1; w.memAddrSel = 1'b1;
      end
      default: w.seq = SEQ_ZERO;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ucodeRom.sv
module ucodeRom
  import ucodePkg::*;
#(
  parameter int STATE_BITS = ucodePkg::STATE_W
) (
  input  logic [STATE_BITS-1:0] uState,
  output ctrlWord_t             word
);
  localparam int DEPTH = 1 << STATE_BITS;

  ctrlWord_t romTable [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign romTable[i] = ucodeEntry(STATE_W'(i));
  end

  assign word = romTable[uState];
endmodule

// File: rtl/nextAddrSel.sv
module nextAddrSel
  import ucodePkg::*;
#(
  parameter int STATE_BITS = ucodePkg::STATE_W,
  parameter int OPC_BITS   = ucodePkg::OPC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OPC_BITS-1:0]   opcode,
  input  seqSel_e               seq,
  output logic [STATE_BITS-1:0] uState,
  output logic                  illegalOp
);
  logic                  dispHit;
  logic [STATE_BITS-1:0] dispTarget;
  logic [STATE_BITS-1:0] nextState;
  logic                  illegalNext;

  // Opcode dispatch table: first micro-state of each instruction class.
  always_comb begin
    dispHit    = 1'b1;
    dispTarget = ST_FETCH;
    case (opcode)
      OPC_RREG: dispTarget = ST_RR_EXEC;
      OPC_BEQ:  dispTarget = ST_BR_CMP;
      OPC_ORI:  dispTarget = ST_OI_EXEC;
      OPC_LOAD: dispTarget = ST_LD_ADDR;
      OPC_STOR: dispTarget = ST_ST_ADDR;
      default:  dispHit    = 1'b0;
    endcase
  end

  always_comb begin
    case (seq)
      SEQ_INC:  nextState = uState + STATE_BITS'(1);
      SEQ_DISP: nextState = dispTarget;
      default:  nextState = ST_FETCH;
    endcase
    illegalNext = (seq == SEQ_DISP) && !dispHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uState    <= ST_FETCH;
      illegalOp <= 1'b0;
    end else begin
      uState    <= nextState;
      illegalOp <= illegalNext;
    end
  end

  // R2: fetch is always followed by decode
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    uState == ST_FETCH |=> uState == ST_DECODE);

  // R3: decode lands on a class entry state or back on fetch
  a_r3_dispatch_target: assert property (@(posedge clk) disable iff (rst)
    uState == ST_DECODE |=> (uState == ST_FETCH || uState == ST_BR_CMP ||
      uState == ST_RR_EXEC || uState == ST_OI_EXEC ||
      uState == ST_LD_ADDR || uState == ST_ST_ADDR));

  // R9: the flag only appears on the fetch state reached from decode
  a_r9_illegal_at_fetch: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (uState == ST_FETCH && $past(uState) == ST_DECODE));

  // R9: the flag lasts one cycle
  a_r9_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
    illegalOp |=> !illegalOp);

  // R11: no unused micro-state is ever reached
  a_r11_state_range: assert property (@(posedge clk) disable iff (rst)
    uState <= ST_LAST);
endmodule

// File: rtl/aluCtlDecode.sv
module aluCtlDecode
  import ucodePkg::*;
#(
  parameter int FUNCT_BITS = ucodePkg::FUNCT_W,
  parameter int AFN_BITS   = ucodePkg::AFN_W
) (
  input  aluOp_e                aluOp,
  input  logic [FUNCT_BITS-1:0] funct,
  output logic [AFN_BITS-1:0]   aluFunc
);
  logic [AFN_BITS-1:0] fromFunct;

  always_comb begin
    case (funct)
      6'b100000: fromFunct = AFN_ADD;
      6'b100010: fromFunct = AFN_SUB;
      6'b100100: fromFunct = AFN_AND;
      6'b100101: fromFunct = AFN_OR;
      6'b101010: fromFunct = AFN_SLT;
      default:   fromFunct = AFN_BAD;
    endcase
  end

  always_comb begin
    case (aluOp)
      OP_SUB:   aluFunc = AFN_SUB;
      OP_OR:    aluFunc = AFN_OR;
      OP_FUNCT: aluFunc = fromFunct;
      default:  aluFunc = AFN_ADD;
    endcase
  end
endmodule

// File: rtl/ucodeSequencer.sv
module ucodeSequencer
  import ucodePkg::*;
#(
  parameter int STATE_BITS = ucodePkg::STATE_W,
  parameter int OPC_BITS   = ucodePkg::OPC_W,
  parameter int FUNCT_BITS = ucodePkg::FUNCT_W,
  parameter int AFN_BITS   = ucodePkg::AFN_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OPC_BITS-1:0]   opcode,
  input  logic [FUNCT_BITS-1:0] funct,
  input  logic                  aluEqual,
  output logic [STATE_BITS-1:0] uState,
  output logic                  pcWrite,
  output logic                  pcSrc,
  output logic                  irLoad,
  output logic                  aluSelA,
  output logic [1:0]            aluSelB,
  output logic [AFN_BITS-1:0]   aluFunc,
  output logic                  extSign,
  output logic                  memRead,
  output logic                  memWrite,
  output logic                  memAddrSel,
  output logic                  regWrite,
  output logic                  regDst,
  output logic                  regSrc,
  output logic                  illegalOp
);
  ctrlWord_t ctl;

  ucodeRom #(.STATE_BITS(STATE_BITS)) rom_i (
    .uState (uState),
    .word   (ctl)
  );

  nextAddrSel #(.STATE_BITS(STATE_BITS), .OPC_BITS(OPC_BITS)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .seq       (ctl.seq),
    .uState    (uState),
    .illegalOp (illegalOp)
  );

  aluCtlDecode #(.FUNCT_BITS(FUNCT_BITS), .AFN_BITS(AFN_BITS)) alu_i (
    .aluOp   (ctl.aluOp),
    .funct   (funct),
    .aluFunc (aluFunc)
  );

  assign pcWrite    = ctl.pcWr | (ctl.pcWrCond & aluEqual);
  assign pcSrc      = ctl.pcSrc;
  assign irLoad     = ctl.irLoad;
  assign aluSelA    = ctl.aluSelA;
  assign aluSelB    = ctl.aluSelB;
  assign extSign    = ctl.extSign;
  assign memRead    = ctl.memRd;
  assign memWrite   = ctl.memWr;
  assign memAddrSel = ctl.memAddrSel;
  assign regWrite   = ctl.regWr;
  assign regDst     = ctl.regDst;
  assign regSrc     = ctl.regSrc;

  // R4: the PC is written only in fetch and branch completion
  a_r4_pc_write_states: assert property (@(posedge clk) disable iff (rst)
    pcWrite |-> (uState == ST_FETCH || uState == ST_BR_TAKE));

  // R7: memory never reads and writes in one cycle
  a_r7_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // R7, R8: data accesses address memory through the ALU result
  a_r7_data_addr: assert property (@(posedge clk) disable iff (rst)
    ((memRead || memWrite) && uState != ST_FETCH) |-> memAddrSel);

  // R2: instruction fetch addresses memory with the PC
  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    irLoad |-> (!memAddrSel && memRead));

  // R5: register writes follow an execute or memory state
  a_r5_write_after_exec: assert property (@(posedge clk) disable iff (rst)
    regWrite |-> ($past(uState) == ST_RR_EXEC || $past(uState) == ST_OI_EXEC ||
      $past(uState) == ST_LD_MEM));
endmodule

// File: tb/ucodeSequencer_tb_top.sv
`timescale 1ns/1ps
module ucodeSequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic       aluEqual = 1'b0;
  logic [3:0] uState;
  logic       pcWrite, pcSrc, irLoad, aluSelA;
  logic [1:0] aluSelB;
  logic [3:0] aluFunc;
  logic       extSign, memRead, memWrite, memAddrSel;
  logic       regWrite, regDst, regSrc, illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucodeSequencer dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .aluEqual(aluEqual),
    .uState(uState), .pcWrite(pcWrite), .pcSrc(pcSrc), .irLoad(irLoad),
    .aluSelA(aluSelA), .aluSelB(aluSelB), .aluFunc(aluFunc), .extSign(extSign),
    .memRead(memRead), .memWrite(memWrite), .memAddrSel(memAddrSel),
    .regWrite(regWrite), .regDst(regDst), .regSrc(regSrc), .illegalOp(illegalOp)
  );

  function automatic bit legalOpc(input logic [5:0] o);
    return o == 6'b000000 || o == 6'b000100 || o == 6'b001101 ||
           o == 6'b100011 || o == 6'b101011;
  endfunction

  function automatic logic [3:0] expNext(input logic [3:0] s, input logic [5:0] o);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (o)
              6'b000000: return 4'd4;
              6'b000100: return 4'd2;
              6'b001101: return 4'd6;
              6'b100011: return 4'd8;
              6'b101011: return 4'd11;
              default:   return 4'd0;
            endcase
      4'd2, 4'd4, 4'd6, 4'd8, 4'd9, 4'd11: return s + 4'd1;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] expAlu(input logic [5:0] f);
    case (f)
      6'b100000: return 4'b0010;
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b1111;
    endcase
  endfunction

  // {pcWrite,pcSrc,irLoad,aluSelA,aluSelB,aluFunc,extSign,memRead,memWrite,
  //  memAddrSel,regWrite,regDst,regSrc}
  function automatic logic [16:0] expCtrl(input logic [3:0] s, input logic [5:0] f,
                                          input logic eq);
    logic pw, ps, ir, sa, es, mr, mw, ma, rw, rd, rs;
    logic [1:0] sb;
    logic [3:0] af;
    {pw, ps, ir, sa, es, mr, mw, ma, rw, rd, rs} = '0;
    sb = 2'b00;
    af = 4'b0010;
    case (s)
      4'd0:  begin pw = 1; ir = 1; mr = 1; sb = 2'b01; end
      4'd2:  begin sa = 1; af = 4'b0110; end
      4'd3:  begin pw = eq; ps = 1; sb = 2'b11; es = 1; end
      4'd4:  begin sa = 1; af = expAlu(f); end
      4'd5:  begin rw = 1; rd = 1; end
      4'd6:  begin sa = 1; sb = 2'b10; af = 4'b0001; end
      4'd7:  rw = 1;
      4'd8, 4'd11: begin sa = 1; sb = 2'b10; es = 1; end
      4'd9:  begin mr = 1; ma = 1; end
      4'd10: begin rw = 1; rs = 1; end
      4'd12: begin mw = 1; ma = 1; end
      default: ;
    endcase
    return {pw, ps, ir, sa, sb, af, es, mr, mw, ma, rw, rd, rs};
  endfunction

  function automatic string tagOf(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3/R11";
      4'd2, 4'd3: return "R4";
      4'd4: return "R10";
      4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9, 4'd10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  function automatic logic [16:0] actCtrl();
    return {pcWrite, pcSrc, irLoad, aluSelA, aluSelB, aluFunc, extSign,
            memRead, memWrite, memAddrSel, regWrite, regDst, regSrc};
  endfunction

  // Runs one instruction from fetch back to fetch.
  task automatic runInstr(input logic [5:0] o, input logic [5:0] f, input logic eq);
    logic [3:0] s;
    logic expIll;
    opcode = o;
    funct = f;
    aluEqual = eq;
    s = 4'd0;
    for (int n = 0; n < 8; n++) begin
      check({tagOf(s), " state"}, 32'(uState), 32'(s));
      check({tagOf(s), " strobes"}, 32'(actCtrl()), 32'(expCtrl(s, f, eq)));
      expIll = (s == 4'd1) && !legalOpc(o);
      s = expNext(s, o);
      step();
      if (s == 4'd0) begin
        check("R9 illegal flag", 32'(illegalOp), 32'(expIll));
        break;
      end
      check("R9 flag idle", 32'(illegalOp), 32'd0);
    end
    check("R9 fetch state", 32'(uState), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    check("R1 reset state", 32'(uState), 32'd0);
    check("R1 reset flag", 32'(illegalOp), 32'd0);
    rst = 1'b0;

    // All opcodes, both equality values (R3, R4, R9, R11).
    for (int o = 0; o < 64; o++) begin
      for (int e = 0; e < 2; e++) begin
        runInstr(6'(o), 6'b100000, 1'(e));
      end
    end

    // All function codes on the register operation (R5, R10).
    for (int f = 0; f < 64; f++) begin
      runInstr(6'b000000, 6'(f), 1'b1);
    end

    // R1: reset in the middle of a load.
    opcode = 6'b100011;
    step(); step(); step();
    check("R7 mid-load state", 32'(uState), 32'd9);
    rst = 1'b1;
    step();
    check("R1 reset mid-sequence", 32'(uState), 32'd0);
    rst = 1'b0;

    // R1: reset while an unknown opcode is being dispatched.
    opcode = 6'b111111;
    step();
    check("R3 decode state", 32'(uState), 32'd1);
    rst = 1'b1;
    step();
    check("R1 reset beats dispatch state", 32'(uState), 32'd0);
    check("R1 reset clears illegal", 32'(illegalOp), 32'd0);
    rst = 1'b0;

    // R11: opcode changes inside a class do not alter its strobes.
    opcode = 6'b101011;
    aluEqual = 1'b1;
    step(); step();
    opcode = 6'b000100;
    check("R11 store addr state", 32'(uState), 32'd11);
    check("R11 strobes ignore opcode", 32'(actCtrl()), 32'(expCtrl(4'd11, funct, 1'b1)));
    step();
    check("R8 store mem state", 32'(uState), 32'd12);
    step();
    check("R8 return to fetch", 32'(uState), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule